// File: doc/BRIEF.md
# Predictive Boundary-Mode Period Calculator

This block predicts the length of the next switching period of a boost power-factor stage so that the inductor current reaches zero exactly at the end of that period. It does this from sampled quantities, with no zero-current detector. On a start strobe it captures the input and output voltage samples, one inductor-current sample, the on-time command and a nominal inductance constant. It then evaluates one of three period formulas and returns a 12-bit period count together with a one-clock done pulse.

The mode input states where in the cycle the current was sampled. The valley sample goes with trailing-edge modulation, the peak sample with leading-edge modulation, and the mid-on-time average with triangular modulation. All three formulas take the form `L·I/(Vout−Vin) + Ton + k·Ton·Vin/(Vout−Vin)` with k = 1, 0 or 1/2. One shared multiplier builds a single numerator and one bit-serial restoring divider divides it by the volt-second difference. The latency is therefore fixed. It must fit inside the compute window that the chosen modulation leaves, which is roughly D·Ts, (1−D)·Ts or (1−D)/2·Ts. The scaling of `l_nom` is chosen by the integrator so that `l_nom·I/V` comes out directly in period counts. An `l_nom` above the true inductance pushes the converter toward discontinuous conduction, and one below it pushes the converter toward continuous conduction.

Top module: `bcm_period_calc`

## Requirements
- R1: After reset, `done` and `sat` are 0 and `period` holds P_MAX (default 4000).
- R2: With mode 2'b00 (valley sample, trailing edge), the result is clamp(floor((floor(N/D)+1)/2) + Ton), where N = 2·L·I + 2·Ton·Vin and D = Vout−Vin.
- R3: With mode 2'b01 (peak sample, leading edge), the same expression applies with N = 2·L·I, so the input voltage does not scale the on-time term.
- R4: With mode 2'b10 or 2'b11 (average sample, triangular), the same expression applies with N = 2·L·I + Ton·Vin.
- R5: The divided term is rounded half-up to a whole count. An exact fraction of .5 rounds up and .25 rounds down.
- R6: The result is clamped to the range [P_MIN, P_MAX], default [1000, 4000].
- R7: When Vout−Vin ≤ 0 the divide is skipped. `period` becomes P_MAX, `sat` pulses with `done`, and `done` rises on the first rising edge after the edge that sampled `start`.
- R8: Otherwise `done` rises on rising edge NUM_W+3 after the edge that sampled `start` (29 with defaults), whatever the data values.
- R9: `done` and `sat` are high for one clock only, and `period` does not change between done pulses.
- R10: A `start` that arrives while a computation is running is ignored. Only one done pulse follows, and it carries the first result.
- R11: Operands are captured on the accepted `start`. Input changes after that edge have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a prediction when idle |
| mode | input | 2 | Sampling point / modulation select |
| vin_smp | input | V_W | Sampled rectified input voltage |
| vout_smp | input | V_W | Sampled output voltage |
| il_smp | input | I_W | Sampled inductor current (valley, peak or average) |
| ton_cmd | input | TON_W | On-time command in counts |
| l_nom | input | L_W | Nominal inductance constant, scaled to counts |
| period | output | OUT_W | Predicted next period in counts |
| done | output | 1 | One-clock result strobe |
| sat | output | 1 | Non-positive voltage difference seen, result forced to maximum |

## Verification
A normal prediction is due 29 rising edges after the edge that samples `start`, and a saturated one is due on the next edge. The bench counts falling edges from the launch and records the first one at which `done` is high. It expects 30 for a normal prediction and 2 for a saturated one, and it reads `period` and `sat` at that same falling edge. The busy and late-change cases disturb the inputs at count 3, well inside the window. For the busy case the bench then watches a further 40 cycles to confirm that no second pulse appears.

// File: rtl/bcm_period_pkg.sv
`timescale 1ns/1ps
package bcm_period_pkg;

    typedef enum logic [1:0] {
        MODE_VALLEY = 2'b00,
        MODE_PEAK   = 2'b01,
        MODE_AVG    = 2'b10,
        MODE_AVG2   = 2'b11
    } smp_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_ACC   = 3'd2,
        ST_DIV   = 3'd3,
        ST_ROUND = 3'd4
    } calc_state_e;

endpackage

// File: rtl/bcm_mul.sv
`timescale 1ns/1ps
module bcm_mul #(
    parameter int A_W = 12,
    parameter int B_W = 12
) (
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    output logic [A_W+B_W-1:0] p
);
    localparam int P_W = A_W + B_W;

    always_comb begin
        p = P_W'(a) * P_W'(b);
    end
endmodule

// File: rtl/bcm_div_step.sv
`timescale 1ns/1ps
module bcm_div_step #(
    parameter int W = 12
) (
    input  logic [W-1:0] rem_i,
    input  logic         bit_i,
    input  logic [W-1:0] div_i,
    output logic [W-1:0] rem_o,
    output logic         q_o
);
    logic [W:0] trial;
    logic [W:0] sub;

    always_comb begin
        trial = {rem_i, bit_i};
        sub   = trial - {1'b0, div_i};
        q_o   = (trial >= {1'b0, div_i});
        rem_o = q_o ? sub[W-1:0] : trial[W-1:0];
    end
endmodule

// File: rtl/bcm_round_clamp.sv
`timescale 1ns/1ps
module bcm_round_clamp #(
    parameter int Q_W   = 26,
    parameter int TON_W = 12,
    parameter int OUT_W = 12,
    parameter int P_MIN = 1000,
    parameter int P_MAX = 4000
) (
    input  logic [Q_W-1:0]   quo,
    input  logic [TON_W-1:0] ton,
    output logic [OUT_W-1:0] cnt
);
    localparam int S_W = ((Q_W > TON_W) ? Q_W : TON_W) + 2;

    logic [S_W-1:0] half;
    logic [S_W-1:0] total;

    always_comb begin
        half  = (S_W'(quo) + S_W'(1)) >> 1;
        total = half + S_W'(ton);
        if (total < S_W'(P_MIN)) begin
            cnt = OUT_W'(P_MIN);
        end else if (total > S_W'(P_MAX)) begin
            cnt = OUT_W'(P_MAX);
        end else begin
            cnt = total[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/bcm_period_calc.sv
`timescale 1ns/1ps
module bcm_period_calc
    import bcm_period_pkg::*;
#(
    parameter int V_W   = 12,
    parameter int I_W   = 12,
    parameter int L_W   = 12,
    parameter int TON_W = 12,
    parameter int OUT_W = 12,
    parameter int P_MIN = 1000,
    parameter int P_MAX = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [V_W-1:0]   vin_smp,
    input  logic [V_W-1:0]   vout_smp,
    input  logic [I_W-1:0]   il_smp,
    input  logic [TON_W-1:0] ton_cmd,
    input  logic [L_W-1:0]   l_nom,
    output logic [OUT_W-1:0] period,
    output logic             done,
    output logic             sat
);
    localparam int MUL_A_W = (L_W > TON_W) ? L_W : TON_W;
    localparam int MUL_B_W = (I_W > V_W) ? I_W : V_W;
    localparam int P_W     = MUL_A_W + MUL_B_W;
    localparam int NUM_W   = P_W + 2;
    localparam int CNT_W   = $clog2(NUM_W + 1);

    typedef struct packed {
        calc_state_e      state;
        smp_mode_e        mode;
        logic [V_W-1:0]   vin;
        logic [V_W-1:0]   vout;
        logic [I_W-1:0]   il;
        logic [TON_W-1:0] ton;
        logic [L_W-1:0]   lnom;
        logic [NUM_W-1:0] num;
        logic [V_W-1:0]   rem;
        logic [CNT_W-1:0] cnt;
        logic [OUT_W-1:0] period;
        logic             done;
        logic             sat;
    } calc_regs_t;

    calc_regs_t r_q, r_d;

    logic [MUL_A_W-1:0] mul_a;
    logic [MUL_B_W-1:0] mul_b;
    logic [P_W-1:0]     prod;
    logic [V_W:0]       vdiff;
    logic               vdiff_ok;
    logic [NUM_W-1:0]   ton_term;
    logic [V_W-1:0]     step_rem;
    logic               step_q;
    logic [OUT_W-1:0]   rounded;

    bcm_mul #(.A_W(MUL_A_W), .B_W(MUL_B_W)) u_mul (
        .a (mul_a),
        .b (mul_b),
        .p (prod)
    );

    bcm_div_step #(.W(V_W)) u_step (
        .rem_i (r_q.rem),
        .bit_i (r_q.num[NUM_W-1]),
        .div_i (vdiff[V_W-1:0]),
        .rem_o (step_rem),
        .q_o   (step_q)
    );

    bcm_round_clamp #(
        .Q_W   (NUM_W),
        .TON_W (TON_W),
        .OUT_W (OUT_W),
        .P_MIN (P_MIN),
        .P_MAX (P_MAX)
    ) u_rc (
        .quo (r_q.num),
        .ton (r_q.ton),
        .cnt (rounded)
    );

    always_comb begin
        vdiff    = {1'b0, r_q.vout} - {1'b0, r_q.vin};
        vdiff_ok = !vdiff[V_W] && (vdiff != '0);

        mul_a = '0;
        mul_b = '0;
        if (r_q.state == ST_LOAD) begin
            mul_a = MUL_A_W'(r_q.lnom);
            mul_b = MUL_B_W'(r_q.il);
        end else if (r_q.state == ST_ACC) begin
            mul_a = MUL_A_W'(r_q.ton);
            mul_b = MUL_B_W'(r_q.vin);
        end

        case (r_q.mode)
            MODE_VALLEY: ton_term = NUM_W'(prod) << 1;
            MODE_PEAK:   ton_term = '0;
            default:     ton_term = NUM_W'(prod);
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.sat  = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.mode  = smp_mode_e'(mode);
                    r_d.vin   = vin_smp;
                    r_d.vout  = vout_smp;
                    r_d.il    = il_smp;
                    r_d.ton   = ton_cmd;
                    r_d.lnom  = l_nom;
                    r_d.state = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (!vdiff_ok) begin
                    r_d.period = OUT_W'(P_MAX);
                    r_d.done   = 1'b1;
                    r_d.sat    = 1'b1;
                    r_d.state  = ST_IDLE;
                end else begin
                    r_d.num   = NUM_W'(prod) << 1;
                    r_d.state = ST_ACC;
                end
            end
            ST_ACC: begin
                r_d.num   = r_q.num + ton_term;
                r_d.rem   = '0;
                r_d.cnt   = CNT_W'(NUM_W);
                r_d.state = ST_DIV;
            end
            ST_DIV: begin
                r_d.rem = step_rem;
                r_d.num = {r_q.num[NUM_W-2:0], step_q};
                r_d.cnt = r_q.cnt - CNT_W'(1);
                if (r_q.cnt == CNT_W'(1)) begin
                    r_d.state = ST_ROUND;
                end
            end
            ST_ROUND: begin
                r_d.period = rounded;
                r_d.done   = 1'b1;
                r_d.state  = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_IDLE;
            r_q.mode   <= MODE_VALLEY;
            r_q.period <= OUT_W'(P_MAX);
        end else begin
            r_q <= r_d;
        end
    end

    assign period = r_q.period;
    assign done   = r_q.done;
    assign sat    = r_q.sat;

endmodule

// File: rtl/bcm_period_chk.sv
`timescale 1ns/1ps
module bcm_period_chk #(
    parameter int OUT_W = 12,
    parameter int P_MIN = 1000,
    parameter int P_MAX = 4000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OUT_W-1:0] period,
    input logic             done,
    input logic             sat
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(period));

    // R6
    period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (period >= OUT_W'(P_MIN)) && (period <= OUT_W'(P_MAX)));

    // R7
    sat_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat |-> done && (period == OUT_W'(P_MAX)));
endmodule

bind bcm_period_calc bcm_period_chk #(
    .OUT_W (OUT_W),
    .P_MIN (P_MIN),
    .P_MAX (P_MAX)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (period),
    .done   (done),
    .sat    (sat)
);

// File: tb/tb_bcm_period_calc.sv
`timescale 1ns/1ps
module tb_bcm_period_calc;
    localparam int W      = 12;
    localparam int PMIN   = 1000;
    localparam int PMAX   = 4000;
    localparam int NUMW   = 2 * W + 2;
    localparam int K_NORM = NUMW + 4;
    localparam int K_SAT  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [W-1:0]  vin_smp = '0, vout_smp = '0, il_smp = '0, ton_cmd = '0, l_nom = '0;
    logic [W-1:0]  period;
    logic          done, sat;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    bcm_period_calc dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .vin_smp(vin_smp), .vout_smp(vout_smp), .il_smp(il_smp),
        .ton_cmd(ton_cmd), .l_nom(l_nom),
        .period(period), .done(done), .sat(sat)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint model(input int md, input int vin, input int vout,
                                     input int il, input int ton, input int l);
        longint d, n, q, p;
        int c;
        d = longint'(vout) - longint'(vin);
        if (d <= 0) return PMAX;
        c = (md == 0) ? 2 : ((md == 1) ? 0 : 1);
        n = 2 * longint'(l) * longint'(il) + longint'(c) * longint'(ton) * longint'(vin);
        q = n / d;
        p = (q + 1) / 2 + longint'(ton);
        if (p < PMIN) p = PMIN;
        if (p > PMAX) p = PMAX;
        return p;
    endfunction

    // poke: 0 none, 1 second start with other operands, 2 operands change only
    task automatic run(input string req, input int md, input int vin, input int vout,
                       input int il, input int ton, input int l, input int poke);
        int k;
        longint expp;
        bit exps;
        expp = model(md, vin, vout, il, ton, l);
        exps = (vout <= vin);
        @(negedge clk);
        mode = 2'(md); vin_smp = W'(vin); vout_smp = W'(vout);
        il_smp = W'(il); ton_cmd = W'(ton); l_nom = W'(l);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
            if (poke != 0 && k == 3) begin
                mode = 2'b01; vin_smp = W'(200); vout_smp = W'(3900);
                il_smp = W'(4000); ton_cmd = W'(3000); l_nom = W'(900);
                start = (poke == 1);
            end
            if (k == 4) start = 1'b0;
        end
        chk(exps ? "R7" : "R8", {req, " latency"}, k, exps ? K_SAT : K_NORM);
        chk(req, "period", period, expp);
        chk(exps ? "R7" : req, "sat", sat, exps);
    endtask

    task automatic t_reset();
        chk("R1", "done after reset", done, 0);
        chk("R1", "sat after reset", sat, 0);
        chk("R1", "period after reset", period, PMAX);
    endtask

    task automatic t_trail();
        run("R2", 0, 1000, 3000, 2000, 800, 100, 0);
        run("R2", 0, 300, 3800, 1500, 1200, 700, 0);
    endtask

    task automatic t_lead();
        run("R3", 1, 1000, 3000, 2000, 1500, 100, 0);
        run("R3", 1, 2500, 3000, 700, 1100, 300, 0);
    endtask

    task automatic t_tri();
        run("R4", 2, 1000, 3000, 2000, 800, 100, 0);
        run("R4", 3, 1000, 3000, 2000, 800, 100, 0);
        run("R4", 2, 1800, 3900, 3000, 1000, 250, 0);
    endtask

    task automatic t_round();
        run("R5", 1, 1000, 1004, 1001, 1000, 2, 0);
        chk("R5", "half rounds up", period, 1501);
        run("R5", 1, 1000, 1004, 2001, 1000, 1, 0);
        chk("R5", "quarter rounds down", period, 1500);
    endtask

    task automatic t_clamp();
        run("R6", 1, 1000, 3000, 2000, 100, 10, 0);
        chk("R6", "low clamp", period, PMIN);
        run("R6", 0, 1000, 1100, 4000, 2000, 4000, 0);
        chk("R6", "high clamp", period, PMAX);
    endtask

    task automatic t_sat();
        run("R7", 1, 1000, 3000, 2000, 100, 10, 0);
        run("R7", 0, 2000, 2000, 1000, 900, 100, 0);
        run("R7", 2, 3000, 1500, 1000, 900, 100, 0);
    endtask

    task automatic t_hold();
        longint held;
        run("R9", 2, 1000, 3000, 2000, 800, 100, 0);
        held = period;
        @(negedge clk);
        chk("R9", "done width", done, 0);
        chk("R9", "sat width", sat, 0);
        repeat (5) @(negedge clk);
        chk("R9", "period held", period, held);
    endtask

    task automatic t_busy();
        int extra;
        run("R10", 0, 1000, 3000, 2000, 800, 100, 1);
        extra = 0;
        repeat (40) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R10", "extra done pulses", extra, 0);
    endtask

    task automatic t_late();
        run("R11", 2, 1800, 3900, 3000, 1000, 250, 2);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_trail();
        t_lead();
        t_tri();
        t_round();
        t_clamp();
        t_sat();
        t_hold();
        t_busy();
        t_late();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule